// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a serial-peripheral master with eight-entry transmit and receive queues. The surrounding register logic drives its settings directly: clock mode, frame length, inter-frame gap, clock divider and receive enable. Software pushes 32-bit words into the transmit queue and then requests a transaction of N frames. The block lowers a single chip select, shifts each frame out on the serial clock and data-out lines, and captures the data-in line into the receive queue. It releases chip select when the last frame has finished.

Seven sticky event flags report queue faults, queue fill level and transaction completion. Each flag is cleared by a write-one pulse on its clear bit. The interrupt line combines the flags with a per-bit enable mask. A global enable input gates the acceptance of new requests.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, chip select is high, all seven flags are zero, the interrupt is low and the serial clock sits at the idle level of the current mode.
- R2: A request is acknowledged only when the enable input is high, no transaction is running and the frame count (1 to 255) is nonzero. `busy_o` stays high from the cycle after acceptance until chip select rises.
- R3: The mode field encodes the idle clock level in bit 1 and the sampling phase in bit 0. Phase 0 samples on the leading edge and phase 1 on the trailing edge. Each serial clock half-period lasts div+1 system clocks.
- R4: A frame carries bits L-1 down to 0 of its queue word, most significant first, where L is the length field (0 acts as 1, above 32 acts as 32). The received frame is stored right-aligned and zero-extended.
- R5: Chip select stays low for exactly (div+1)*(2 + 2*F*L + 2*(F-1)*gap) system clocks: one half-period before the first edge, gap idle clock periods between frames, and one half-period after the last edge.
- R6: When a frame is due and the transmit queue is empty, the frame shifts out zeros and flag bit 3 sets.
- R7: With receive enable clear, captured frames are discarded and the receive queue stays empty.
- R8: A frame that completes while the receive queue is full is dropped and sets flag bit 1. A read of an empty receive queue sets flag bit 0.
- R9: A write to a full transmit queue is dropped and sets flag bit 4. Flag bit 5 (transmit) and flag bit 2 (receive) set while the matching queue holds 6 or more words.
- R10: Flag bit 6 sets on the same edge on which chip select returns high at the end of a transaction.
- R11: Flags stay set until a clear pulse with a one in their bit. `irq_o` is high exactly when some set flag has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable for request acceptance |
| mode_i | input | 2 | Bit 1 idle clock level, bit 0 sampling phase |
| bit_len_i | input | 8 | Frame length in bits |
| gap_i | input | 8 | Idle clock periods between frames |
| div_i | input | 8 | Half-period length minus one, in system clocks |
| rx_en_i | input | 1 | Store received frames |
| tx_wr_i | input | 1 | Push `tx_data_i` into the transmit queue |
| tx_data_i | input | 32 | Transmit word |
| rx_rd_i | input | 1 | Pop the receive queue |
| rx_data_o | output | 32 | Head of the receive queue |
| rx_empty_o | output | 1 | Receive queue empty |
| req_i | input | 1 | Transaction request pulse |
| req_frames_i | input | 8 | Frames in the requested transaction |
| req_ack_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | Transaction in progress |
| irq_mask_i | input | 7 | Per-flag interrupt enable |
| irq_clr_i | input | 7 | Write-one-to-clear pulse per flag |
| irq_flags_o | output | 7 | Sticky flags: 0 rx underflow, 1 rx overflow, 2 rx almost full, 3 tx underflow, 4 tx overflow, 5 tx almost full, 6 done |
| irq_o | output | 1 | Masked interrupt |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The bench loops the data-out line back into data-in, optionally inverted, and walks all four modes. It covers frame lengths of 1, 5, 8, 16 and 32 and the out-of-range lengths 0 and 40, with and without gaps. A phase or edge error would corrupt the received words. A wrong half-period or gap count would move the measured chip-select window and the shortest clock half-period away from their formulas. The queue edges are driven hard: a ninth transmit write that overwrote data would show up in the serial stream, and a frame taken from an empty queue would show nonzero bits. A receive push into a full queue that was not dropped would disturb the eight words read back. Requests made while disabled, busy or with a zero count must not be acknowledged, and a flag that failed to stay sticky or ignored its mask would show at the flag and interrupt outputs.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int N_IRQ      = 7;
  localparam int IRQ_RX_UNF = 0;
  localparam int IRQ_RX_OVF = 1;
  localparam int IRQ_RX_AF  = 2;
  localparam int IRQ_TX_UNF = 3;
  localparam int IRQ_TX_OVF = 4;
  localparam int IRQ_TX_AF  = 5;
  localparam int IRQ_DONE   = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITS,
    ST_GAP,
    ST_TAIL
  } eng_state_e;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int AFULL = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o,
  output logic         afull_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, wr_ok, rd_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign afull_o = (cnt >= CW'(AFULL));
  assign wr_ok   = wr_i && !full;
  assign rd_ok   = rd_i && !empty_o;
  assign ovf_o   = wr_i && full;
  assign unf_o   = rd_i && empty_o;
  assign rd_data_o = mem[rp];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wp] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) flags_o[i] <= 1'b0;
    end
  end

  assign irq_o = |(flags_o & mask_i);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  frames_i,
  input  logic [1:0]        mode_i,
  input  logic [CFG_W-1:0]  len_i,
  input  logic [CFG_W-1:0]  gap_i,
  input  logic [CFG_W-1:0]  div_i,
  input  logic              rx_en_i,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int LEN_W = IDX_W + 1;
  localparam int H_W   = LEN_W + 1;
  localparam int G_W   = CFG_W + 1;

  function automatic logic [LEN_W-1:0] eff_len(input logic [CFG_W-1:0] l);
    if (l == '0)              return LEN_W'(1);
    else if (int'(l) >= DATA_W) return LEN_W'(DATA_W);
    else                      return l[LEN_W-1:0];
  endfunction

  eng_state_e        st;
  logic [CFG_W-1:0]  cnt, rem, gap_q, div_q;
  logic [H_W-1:0]    h, h_max;
  logic [G_W-1:0]    g, g_max;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        mode_q;
  logic              rx_en_q, sclk_int, mosi_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, tx_word;
  logic              tick, h_last, drive, more, load;

  assign tick    = (st != ST_IDLE) && (cnt == div_q);
  assign h_max   = {len_q, 1'b0} - H_W'(1);
  assign g_max   = {gap_q, 1'b0} - G_W'(1);
  assign h_last  = (h == h_max);
  assign idx     = IDX_W'(len_q - LEN_W'(1));
  assign drive   = h[0] ^ mode_q[0];  // phase 0 drives on trailing edges
  assign more    = (rem != CFG_W'(1));
  assign load    = tick && ((st == ST_LEAD) ||
                            (st == ST_GAP  && g == g_max) ||
                            (st == ST_BITS && h_last && more && gap_q == '0));
  assign tx_word = tx_empty_i ? '0 : tx_data_i;

  assign tx_pop_o  = load;
  assign rx_data_o = drive ? rx_sh : {rx_sh[DATA_W-2:0], miso_i};
  assign rx_push_o = tick && (st == ST_BITS) && h_last && rx_en_q;
  assign done_o    = tick && (st == ST_TAIL);
  assign busy_o    = (st != ST_IDLE);
  assign cs_no     = !busy_o;
  assign mosi_o    = mosi_q;
  assign sclk_o    = ((st == ST_IDLE) ? mode_i[1] : mode_q[1]) ^ sclk_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rem      <= '0;
      gap_q    <= '0;
      div_q    <= '0;
      len_q    <= LEN_W'(1);
      mode_q   <= '0;
      rx_en_q  <= 1'b0;
      h        <= '0;
      g        <= '0;
      sclk_int <= 1'b0;
      mosi_q   <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      if (st == ST_IDLE || tick) cnt <= '0;
      else                       cnt <= cnt + CFG_W'(1);

      case (st)
        ST_IDLE: if (start_i) begin
          len_q   <= eff_len(len_i);
          gap_q   <= gap_i;
          div_q   <= div_i;
          mode_q  <= mode_i;
          rx_en_q <= rx_en_i;
          rem     <= frames_i;
          st      <= ST_LEAD;
        end
        ST_BITS: if (tick) begin
          sclk_int <= ~sclk_int;
          if (drive) begin
            mosi_q <= tx_sh[idx];
            tx_sh  <= tx_sh << 1;
          end else begin
            rx_sh  <= rx_data_o;
          end
          if (h_last) begin
            rem <= rem - CFG_W'(1);
            h   <= '0;
            if (!more) st <= ST_TAIL;
            else if (gap_q != '0) begin
              st <= ST_GAP;
              g  <= '0;
            end
          end else begin
            h <= h + H_W'(1);
          end
        end
        ST_GAP: if (tick && g != g_max) g <= g + G_W'(1);
        ST_TAIL: if (tick) begin
          st     <= ST_IDLE;
          mosi_q <= 1'b0;
        end
        default: ;
      endcase

      if (load) begin
        st    <= ST_BITS;
        h     <= '0;
        rx_sh <= '0;
        if (!mode_q[0]) begin
          mosi_q <= tx_word[idx];
          tx_sh  <= tx_word << 1;
        end else begin
          tx_sh  <= tx_word;
        end
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CFG_W      = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int AFULL_LVL  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [CFG_W-1:0]  bit_len_i,
  input  logic [CFG_W-1:0]  gap_i,
  input  logic [CFG_W-1:0]  div_i,
  input  logic              rx_en_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_empty_o,
  input  logic              req_i,
  input  logic [CFG_W-1:0]  req_frames_i,
  output logic              req_ack_o,
  output logic              busy_o,
  input  logic [N_IRQ-1:0]  irq_mask_i,
  input  logic [N_IRQ-1:0]  irq_clr_i,
  output logic [N_IRQ-1:0]  irq_flags_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  logic              tx_pop, tx_empty, tx_af, tx_ovf, tx_unf;
  logic [DATA_W-1:0] tx_head, eng_rx_data;
  logic              rx_push, rx_af, rx_ovf, rx_unf, done;
  logic [N_IRQ-1:0]  irq_set;

  assign req_ack_o = req_i && en_i && !busy_o && (req_frames_i != '0);

  spi_sync_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .AFULL(AFULL_LVL)) u_tx_fifo (
    .clk_i, .rst_ni,
    .wr_i(tx_wr_i), .wr_data_i(tx_data_i),
    .rd_i(tx_pop), .rd_data_o(tx_head),
    .empty_o(tx_empty), .afull_o(tx_af), .ovf_o(tx_ovf), .unf_o(tx_unf)
  );

  spi_sync_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .AFULL(AFULL_LVL)) u_rx_fifo (
    .clk_i, .rst_ni,
    .wr_i(rx_push), .wr_data_i(eng_rx_data),
    .rd_i(rx_rd_i), .rd_data_o(rx_data_o),
    .empty_o(rx_empty_o), .afull_o(rx_af), .ovf_o(rx_ovf), .unf_o(rx_unf)
  );

  spi_shift_engine #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_engine (
    .clk_i, .rst_ni,
    .start_i(req_ack_o), .frames_i(req_frames_i),
    .mode_i, .len_i(bit_len_i), .gap_i, .div_i, .rx_en_i,
    .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(eng_rx_data),
    .done_o(done), .busy_o,
    .sclk_o, .mosi_o, .miso_i, .cs_no
  );

  always_comb begin
    irq_set             = '0;
    irq_set[IRQ_RX_UNF] = rx_unf;
    irq_set[IRQ_RX_OVF] = rx_ovf;
    irq_set[IRQ_RX_AF]  = rx_af;
    irq_set[IRQ_TX_UNF] = tx_unf;
    irq_set[IRQ_TX_OVF] = tx_ovf;
    irq_set[IRQ_TX_AF]  = tx_af;
    irq_set[IRQ_DONE]   = done;
  end

  spi_irq_regs #(.N(N_IRQ)) u_irq (
    .clk_i, .rst_ni,
    .set_i(irq_set), .clr_i(irq_clr_i), .mask_i(irq_mask_i),
    .flags_o(irq_flags_o), .irq_o
  );
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk
  import spi_fifo_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic             req_ack_o,
  input logic [CFG_W-1:0] req_frames_i,
  input logic             busy_o,
  input logic [N_IRQ-1:0] irq_clr_i,
  input logic [N_IRQ-1:0] irq_flags_o,
  input logic             sclk_o,
  input logic             cs_no
);
  assert_ack_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |-> (en_i && !busy_o && req_frames_i != '0));

  assert_ack_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |=> (busy_o && !cs_no));

  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (sclk_o == mode_i[1]));

  assert_sclk_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sclk_o) && $stable(mode_i)) |-> !cs_no);

  assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(irq_flags_o) & ~$past(irq_clr_i) & ~irq_flags_o) == '0));

  assert_done_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flags_o[IRQ_DONE]) |-> $rose(cs_no));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
  .req_ack_o(req_ack_o), .req_frames_i(req_frames_i), .busy_o(busy_o),
  .irq_clr_i(irq_clr_i), .irq_flags_o(irq_flags_o),
  .sclk_o(sclk_o), .cs_no(cs_no)
);

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic [1:0]  mode_i = 2'd2;
  logic [7:0]  bit_len_i = 8'd8, gap_i = 8'd0, div_i = 8'd0;
  logic        rx_en_i = 1'b1;
  logic        tx_wr_i = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic        rx_rd_i = 1'b0;
  logic [31:0] rx_data_o;
  logic        rx_empty_o;
  logic        req_i = 1'b0;
  logic [7:0]  req_frames_i = '0;
  logic        req_ack_o, busy_o;
  logic [6:0]  irq_mask_i = '0, irq_clr_i = '0, irq_flags_o;
  logic        irq_o, sclk_o, mosi_o, miso_i, cs_no;
  logic        inv = 1'b0;

  always #5 clk = ~clk;
  assign miso_i = mosi_o ^ inv;

  spi_fifo_master uut (
    .clk_i(clk), .rst_ni, .en_i, .mode_i, .bit_len_i, .gap_i, .div_i, .rx_en_i,
    .tx_wr_i, .tx_data_i, .rx_rd_i, .rx_data_o, .rx_empty_o,
    .req_i, .req_frames_i, .req_ack_o, .busy_o,
    .irq_mask_i, .irq_clr_i, .irq_flags_o, .irq_o,
    .sclk_o, .mosi_o, .miso_i, .cs_no
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // serial-line monitor
  logic        prev_sclk = 1'b0;
  logic [31:0] mon_w = '0;
  logic [31:0] mon_arr [16];
  int mon_bits = 0, mon_idx = 0, cs_low = 0, cyc = 0, last_edge = 0, min_half = 1000, cur_len = 8;
  logic [1:0]  cur_mode = 2'd0;

  always @(negedge clk) begin
    cyc++;
    if (!cs_no) cs_low++;
    if (!cs_no && sclk_o !== prev_sclk) begin
      if (cyc - last_edge < min_half) min_half = cyc - last_edge;
      last_edge = cyc;
      if ((sclk_o != cur_mode[1]) ^ cur_mode[0]) begin
        mon_w = {mon_w[30:0], mosi_o};
        mon_bits++;
        if (mon_bits == cur_len) begin
          if (mon_idx < 16) mon_arr[mon_idx] = mon_w;
          mon_idx++;
          mon_bits = 0;
          mon_w = '0;
        end
      end
    end
    prev_sclk = sclk_o;
  end

  function automatic int efflen(input logic [7:0] l);
    if (l == 0) return 1;
    if (l > 32) return 32;
    return int'(l);
  endfunction

  function automatic logic [31:0] lmask(input int l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 32'd1);
  endfunction

  function automatic logic [31:0] gw(input int i, input int k);
    return (32'h9E37_79B9 * 32'(i * 8 + k + 1)) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic push_tx(input logic [31:0] w);
    @(negedge clk); tx_wr_i = 1'b1; tx_data_i = w;
    @(negedge clk); tx_wr_i = 1'b0;
  endtask

  task automatic pop_rx(output logic [31:0] d, output logic emp);
    @(negedge clk); d = rx_data_o; emp = rx_empty_o; rx_rd_i = 1'b1;
    @(negedge clk); rx_rd_i = 1'b0;
  endtask

  task automatic clr_flags(input logic [6:0] v);
    @(negedge clk); irq_clr_i = v;
    @(negedge clk); irq_clr_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [7:0] l, g, d, input logic rxe, input logic iv);
    @(negedge clk);
    mode_i = m; bit_len_i = l; gap_i = g; div_i = d; rx_en_i = rxe; inv = iv;
    cur_mode = m; cur_len = efflen(l);
    mon_bits = 0; mon_idx = 0; mon_w = '0; cs_low = 0; min_half = 1000; last_edge = cyc;
  endtask

  task automatic request(input logic [7:0] f, output logic ack);
    @(negedge clk); req_i = 1'b1; req_frames_i = f;
    #1 ack = req_ack_o;
    @(negedge clk); req_i = 1'b0;
  endtask

  task automatic wait_done(output logic seen, output logic cs_at);
    seen = 1'b0; cs_at = 1'b0;
    for (int i = 0; i < 50000; i++) begin
      @(negedge clk);
      if (irq_flags_o[6]) begin seen = 1'b1; cs_at = cs_no; break; end
    end
  endtask

  typedef struct packed {
    logic [1:0] m;
    logic [7:0] l;
    logic [7:0] g;
    logic [7:0] d;
    logic [7:0] f;
    logic       iv;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 8'd8,  8'd0, 8'd0, 8'd3, 1'b0},
    '{2'd1, 8'd16, 8'd2, 8'd1, 8'd2, 1'b1},
    '{2'd2, 8'd32, 8'd1, 8'd2, 8'd2, 1'b0},
    '{2'd3, 8'd5,  8'd0, 8'd3, 8'd4, 1'b1},
    '{2'd0, 8'd0,  8'd0, 8'd0, 8'd1, 1'b0},
    '{2'd1, 8'd40, 8'd0, 8'd0, 8'd1, 1'b1}
  };

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack, seen, cs_at, emp;
    logic [31:0] d;
    int l, f, expcs;

    // R1 reset state
    idle(3);
    chk("R1", "cs_no in reset", {31'd0, cs_no}, 32'd1);
    chk("R1", "sclk idle mode2", {31'd0, sclk_o}, 32'd1);
    @(negedge clk); rst_ni = 1'b1;
    idle(2);
    chk("R1", "flags", {25'd0, irq_flags_o}, 32'd0);
    chk("R1", "irq", {31'd0, irq_o}, 32'd0);
    chk("R1", "cs_no", {31'd0, cs_no}, 32'd1);

    // table of transactions
    for (int i = 0; i < 6; i++) begin
      l = efflen(VECS[i].l);
      f = int'(VECS[i].f);
      setup(VECS[i].m, VECS[i].l, VECS[i].g, VECS[i].d, 1'b1, VECS[i].iv);
      for (int k = 0; k < f; k++) push_tx(gw(i, k));
      idle(1);
      chk("R3", "idle level", {31'd0, sclk_o}, {31'd0, VECS[i].m[1]});
      request(VECS[i].f, ack);
      chk("R2", "ack", {31'd0, ack}, 32'd1);
      wait_done(seen, cs_at);
      chk("R10", "done seen", {31'd0, seen}, 32'd1);
      chk("R10", "cs high at done", {31'd0, cs_at}, 32'd1);
      expcs = (int'(VECS[i].d) + 1) * (2 + 2 * f * l + 2 * (f - 1) * int'(VECS[i].g));
      chk("R5", "cs low cycles", cs_low, expcs);
      chk("R3", "half period", min_half, int'(VECS[i].d) + 1);
      chk("R4", "frame count", mon_idx, f);
      for (int k = 0; k < f; k++) begin
        chk("R4", "mosi frame", mon_arr[k], gw(i, k) & lmask(l));
        pop_rx(d, emp);
        chk("R4", "rx frame", d, (VECS[i].iv ? ~gw(i, k) : gw(i, k)) & lmask(l));
      end
      clr_flags(7'h7F);
    end

    // R2 refusals
    en_i = 1'b0;
    request(8'd1, ack);
    chk("R2", "ack while disabled", {31'd0, ack}, 32'd0);
    chk("R2", "busy while disabled", {31'd0, busy_o}, 32'd0);
    en_i = 1'b1;
    request(8'd0, ack);
    chk("R2", "ack zero frames", {31'd0, ack}, 32'd0);
    setup(2'd0, 8'd32, 8'd0, 8'd3, 1'b0, 1'b0);
    request(8'd2, ack);
    chk("R2", "first ack", {31'd0, ack}, 32'd1);
    request(8'd1, ack);
    chk("R2", "ack while busy", {31'd0, ack}, 32'd0);
    chk("R2", "busy", {31'd0, busy_o}, 32'd1);
    wait_done(seen, cs_at);
    idle(2);
    chk("R2", "busy after done", {31'd0, busy_o}, 32'd0);
    clr_flags(7'h7F);

    // R9 tx almost full and overflow
    setup(2'd0, 8'd32, 8'd0, 8'd0, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) push_tx(gw(9, k));
    idle(2);
    chk("R9", "tx afull at 5", {31'd0, irq_flags_o[5]}, 32'd0);
    push_tx(gw(9, 5));
    idle(2);
    chk("R9", "tx afull at 6", {31'd0, irq_flags_o[5]}, 32'd1);
    push_tx(gw(9, 6));
    push_tx(gw(9, 7));
    idle(2);
    chk("R9", "no ovf at 8", {31'd0, irq_flags_o[4]}, 32'd0);
    push_tx(32'hDEAD_BEEF);
    idle(2);
    chk("R9", "tx ovf", {31'd0, irq_flags_o[4]}, 32'd1);
    request(8'd8, ack);
    wait_done(seen, cs_at);
    chk("R9", "frames sent", mon_idx, 8);
    for (int k = 0; k < 8; k++) chk("R9", "kept word", mon_arr[k], gw(9, k));
    idle(2);
    chk("R9", "rx afull", {31'd0, irq_flags_o[2]}, 32'd1);
    chk("R6", "no tx unf yet", {31'd0, irq_flags_o[3]}, 32'd0);
    clr_flags(7'h7F);

    // R6 empty tx, R8 rx overflow
    setup(2'd0, 8'd32, 8'd0, 8'd0, 1'b1, 1'b0);
    request(8'd1, ack);
    wait_done(seen, cs_at);
    chk("R6", "zero frame", mon_arr[0], 32'd0);
    chk("R6", "tx unf flag", {31'd0, irq_flags_o[3]}, 32'd1);
    chk("R8", "rx ovf flag", {31'd0, irq_flags_o[1]}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      pop_rx(d, emp);
      chk("R8", "rx kept word", d, gw(9, k));
    end
    chk("R8", "no rx unf yet", {31'd0, irq_flags_o[0]}, 32'd0);
    pop_rx(d, emp);
    chk("R8", "rx empty", {31'd0, emp}, 32'd1);
    idle(1);
    chk("R8", "rx unf flag", {31'd0, irq_flags_o[0]}, 32'd1);
    clr_flags(7'h7F);

    // R7 receive disabled
    setup(2'd3, 8'd12, 8'd1, 8'd1, 1'b0, 1'b0);
    push_tx(32'h0000_0ABC);
    push_tx(32'h0000_0123);
    request(8'd2, ack);
    wait_done(seen, cs_at);
    chk("R7", "mosi still sent", mon_arr[1], 32'h0000_0123);
    chk("R7", "rx stays empty", {31'd0, rx_empty_o}, 32'd1);

    // R11 sticky, mask and clear (done flag set above)
    pop_rx(d, emp);
    idle(1);
    chk("R11", "two flags", {25'd0, irq_flags_o}, 32'h41);
    irq_mask_i = 7'h00; idle(1);
    chk("R11", "irq masked", {31'd0, irq_o}, 32'd0);
    irq_mask_i = 7'h01; idle(1);
    chk("R11", "irq bit0", {31'd0, irq_o}, 32'd1);
    clr_flags(7'h01);
    idle(1);
    chk("R11", "bit0 cleared, bit6 sticky", {25'd0, irq_flags_o}, 32'h40);
    chk("R11", "irq after clear", {31'd0, irq_o}, 32'd0);
    irq_mask_i = 7'h40; idle(1);
    chk("R11", "irq bit6", {31'd0, irq_o}, 32'd1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule